// File: doc/BRIEF.md
# Five-Channel Serially Programmed Phase Accumulator Bank

This block holds five independent phase accumulators. Each one turns a fixed system clock into a square wave of programmable frequency. Each channel keeps a 24-bit frequency word and a 24-bit phase register. On every system clock edge the channel adds its frequency word to its phase register, and the sum wraps around at 2^24. The top bit of the phase register is the channel's square-wave output. The output frequency is word × fclk / 2^24, so the step size is fclk/2^24. The fastest usable output is fclk/2, which needs the word 2^23. When the ideal period is not a whole number of clock cycles, the output edges move by up to one clock period.

A host processor programs the frequency words through one shared serial path. That path has a data line, a shift clock and a load strobe, and both strobes are sampled by the system clock. Each frame is 27 bits long and is sent most significant bit first: a 3-bit channel number followed by the 24-bit word. A rising edge on the load strobe copies the word into the addressed channel. Channel numbers 5, 6 and 7 select nothing.

Top module: `dds_bank`

## Requirements
- R1: A synchronous reset clears every phase register and every frequency word to zero. All outputs are low in the cycle after reset, and they stay low until a nonzero word is loaded.
- R2: A frame is taken as the last 27 bits shifted in, most significant bit first. Bits 26..24 of the frame are the channel number and bits 23..0 are the frequency word. A rising edge of the load strobe writes that word into the channel named.
- R3: A load with channel number 5, 6 or 7 changes no frequency word and no output.
- R4: On every clock edge after reset, each phase register becomes (phase + word) mod 2^24, with no saturation.
- R5: Output bit c of toneOut is bit 23 of channel c's phase register.
- R6: The word 2^23, loaded after reset, makes the output change level on every clock cycle, which is half the clock frequency.
- R7: A newly loaded word is first added on the clock edge after the one that latches it. Loading a word does not clear the phase register, so the phase stays continuous.
- R8: Channels are independent. Loading one channel does not disturb the phase or the word of any other channel.
- R9: One bit is shifted per rising edge of the shift clock, as seen by the system clock. Holding the shift clock high for several system cycles shifts only one bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; every phase register advances on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| serData | input | 1 | Serial frame data, most significant bit first |
| shiftClk | input | 1 | Serial shift clock; a bit is taken on each rising edge |
| loadStb | input | 1 | Load strobe; a rising edge writes the assembled word to the addressed channel |
| toneOut | output | 5 | Square-wave outputs, bit c being channel c's phase MSB |

## Verification
A wrong phase register or frequency word shows at the ports as a wrong level on that channel's output. This can take many cycles to appear, because only the MSB is visible: a small error moves an edge only when a carry reaches bit 23. The bench therefore follows a reference phase model for every channel and compares all five outputs in every cycle, over windows long enough for several MSB transitions. Misrouted loads, shifted frame bits and a phase that resets on load all show up in these windows. The effect of a newly loaded word appears two edges after the load strobe rises, and an error in its timing shows as one cycle of phase slip.

// File: rtl/dds_pkg.sv
package dds_pkg;
  localparam int ADDR_W = 3;

  // strobes from the serial control to the phase datapath
  typedef struct packed {
    logic              load;
    logic [ADDR_W-1:0] chan;
  } ctrl_t;
endpackage

// File: rtl/ser_ctrl.sv
module ser_ctrl
  import dds_pkg::*;
#(
  parameter int WORD_W = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              serData,
  input  logic              shiftClk,
  input  logic              loadStb,
  output ctrl_t             ctrl,
  output logic [WORD_W-1:0] word
);
  localparam int FRAME_W = ADDR_W + WORD_W;

  logic               prevShift;
  logic               prevLoad;
  logic [FRAME_W-1:0] frameReg;
  logic               shiftRise;

  assign shiftRise = shiftClk & ~prevShift;

  always_ff @(posedge clk) begin
    if (rst) begin
      prevShift <= 1'b0;
      prevLoad  <= 1'b0;
      frameReg  <= '0;
    end else begin
      prevShift <= shiftClk;
      prevLoad  <= loadStb;
      if (shiftRise) frameReg <= {frameReg[FRAME_W-2:0], serData};
    end
  end

  always_comb begin
    ctrl.load = loadStb & ~prevLoad & ~rst;
    ctrl.chan = frameReg[FRAME_W-1 -: ADDR_W];
    word      = frameReg[WORD_W-1:0];
  end
endmodule

// File: rtl/phase_dp.sv
module phase_dp
  import dds_pkg::*;
#(
  parameter int CHANNELS = 5,
  parameter int WORD_W   = 24
) (
  input  logic                         clk,
  input  logic                         rst,
  input  ctrl_t                        ctrl,
  input  logic [WORD_W-1:0]            word,
  output logic [CHANNELS-1:0]          toneOut,
  output logic [CHANNELS*WORD_W-1:0]   tuneFlat,
  output logic [CHANNELS*WORD_W-1:0]   accFlat
);
  for (genvar c = 0; c < CHANNELS; c++) begin : gChan
    logic [WORD_W-1:0] tuneReg;
    logic [WORD_W-1:0] accReg;
    logic              hit;

    assign hit = ctrl.load && (ctrl.chan == ADDR_W'(c));

    always_ff @(posedge clk) begin
      if (rst) begin
        tuneReg <= '0;
        accReg  <= '0;
      end else begin
        accReg <= accReg + tuneReg;
        if (hit) tuneReg <= word;
      end
    end

    assign toneOut[c] = accReg[WORD_W-1];
    assign tuneFlat[c*WORD_W +: WORD_W] = tuneReg;
    assign accFlat[c*WORD_W +: WORD_W]  = accReg;
  end
endmodule

// File: rtl/dds_bank.sv
module dds_bank
  import dds_pkg::*;
#(
  parameter int CHANNELS = 5,
  parameter int PHASE_W  = 24
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                serData,
  input  logic                shiftClk,
  input  logic                loadStb,
  output logic [CHANNELS-1:0] toneOut
);
  ctrl_t                       ctrl;
  logic [PHASE_W-1:0]          word;
  logic [CHANNELS*PHASE_W-1:0] tuneFlat;
  logic [CHANNELS*PHASE_W-1:0] accFlat;

  ser_ctrl #(.WORD_W(PHASE_W)) uCtrl (
    .clk(clk), .rst(rst), .serData(serData), .shiftClk(shiftClk),
    .loadStb(loadStb), .ctrl(ctrl), .word(word)
  );

  phase_dp #(.CHANNELS(CHANNELS), .WORD_W(PHASE_W)) uDp (
    .clk(clk), .rst(rst), .ctrl(ctrl), .word(word),
    .toneOut(toneOut), .tuneFlat(tuneFlat), .accFlat(accFlat)
  );
endmodule

// File: rtl/dds_bank_chk.sv
module dds_bank_chk
  import dds_pkg::*;
#(
  parameter int CHANNELS = 5,
  parameter int PHASE_W  = 24
) (
  input logic                        clk,
  input logic                        rst,
  input logic [CHANNELS-1:0]         toneOut,
  input logic [CHANNELS*PHASE_W-1:0] tuneFlat,
  input logic [CHANNELS*PHASE_W-1:0] accFlat,
  input logic                        loadPulse,
  input logic [ADDR_W-1:0]           loadChan,
  input logic [PHASE_W-1:0]          loadWord
);
  AST_RST_LOW: assert property (@(posedge clk) rst |=> (toneOut == '0)); // R1

  AST_BAD_ADDR: assert property (@(posedge clk) disable iff (rst)
    (loadPulse && (loadChan >= ADDR_W'(CHANNELS))) |=> $stable(tuneFlat)); // R3

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !loadPulse |=> $stable(tuneFlat)); // R8

  for (genvar c = 0; c < CHANNELS; c++) begin : gChk
    AST_LOAD_LAND: assert property (@(posedge clk) disable iff (rst)
      (loadPulse && (loadChan == ADDR_W'(c))) |=>
      (tuneFlat[c*PHASE_W +: PHASE_W] == $past(loadWord))); // R2

    AST_PHASE_STEP: assert property (@(posedge clk) disable iff (rst)
      $past(!rst) |-> (accFlat[c*PHASE_W +: PHASE_W] ==
        $past(accFlat[c*PHASE_W +: PHASE_W] + tuneFlat[c*PHASE_W +: PHASE_W]))); // R4
  end
endmodule

bind dds_bank dds_bank_chk #(.CHANNELS(CHANNELS), .PHASE_W(PHASE_W)) uChk (
  .clk(clk), .rst(rst), .toneOut(toneOut), .tuneFlat(tuneFlat),
  .accFlat(accFlat), .loadPulse(ctrl.load), .loadChan(ctrl.chan), .loadWord(word)
);

// File: tb/tb_dds_bank.sv
`timescale 1ns/1ps
module tb_dds_bank;
  localparam int NCH = 5;
  localparam int PW  = 24;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic serData = 1'b0;
  logic shiftClk = 1'b0;
  logic loadStb = 1'b0;
  logic [NCH-1:0] toneOut;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [PW-1:0] refAcc  [NCH];
  logic [PW-1:0] refTune [NCH];
  logic          pendLoad = 1'b0;
  logic [2:0]    pendChan = '0;
  logic [PW-1:0] pendWord = '0;

  always #2.5 clk = ~clk;

  dds_bank dut (
    .clk(clk), .rst(rst), .serData(serData), .shiftClk(shiftClk),
    .loadStb(loadStb), .toneOut(toneOut)
  );

  // reference phase model from the requirements
  always @(posedge clk) begin
    if (rst) begin
      for (int c = 0; c < NCH; c++) begin
        refAcc[c]  = '0;
        refTune[c] = '0;
      end
      pendLoad = 1'b0;
    end else begin
      for (int c = 0; c < NCH; c++) refAcc[c] = refAcc[c] + refTune[c];
      if (pendLoad && pendChan < 3'(NCH)) refTune[pendChan] = pendWord;
      pendLoad = 1'b0;
    end
  end

  function automatic logic [NCH-1:0] refOut();
    logic [NCH-1:0] v;
    for (int c = 0; c < NCH; c++) v[c] = refAcc[c][PW-1];
    return v;
  endfunction

  task automatic checkVal(string tag, logic [NCH-1:0] act, logic [NCH-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: toneOut=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compareWindow(int n, string tag);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      checkVal(tag, toneOut, refOut());
    end
  endtask

  task automatic sendFrame(logic [2:0] addr, logic [PW-1:0] w, int hold);
    logic [PW+2:0] frame;
    frame = {addr, w};
    for (int i = PW + 2; i >= 0; i--) begin
      @(negedge clk);
      serData  = frame[i];
      shiftClk = 1'b1;
      for (int h = 1; h < hold; h++) @(negedge clk);
      @(negedge clk);
      shiftClk = 1'b0;
    end
    @(negedge clk);
    loadStb  = 1'b1;
    pendLoad = 1'b1;
    pendChan = addr;
    pendWord = w;
    @(negedge clk);
    loadStb = 1'b0;
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    checkVal("R1 reset state", toneOut, '0);
    rst = 1'b0;
  endtask

  task automatic testReset();
    doReset();
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      checkVal("R1 idle low", toneOut, '0);
    end
  endtask

  task automatic testHalfRate();
    logic prev;
    doReset();
    sendFrame(3'd0, 24'h800000, 1);
    @(negedge clk);
    prev = toneOut[0];
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      checkVal("R6 half rate toggle", {4'b0, toneOut[0]}, {4'b0, ~prev});
      prev = toneOut[0];
    end
    compareWindow(16, "R5 msb output");
  endtask

  task automatic testWrap();
    doReset();
    sendFrame(3'd1, 24'h600000, 1);
    compareWindow(32, "R4 wrap modulo");
  endtask

  task automatic testIndependent();
    sendFrame(3'd2, 24'h012345, 1);
    sendFrame(3'd3, 24'h3A0001, 1);
    sendFrame(3'd4, 24'hFFFFF0, 1);
    compareWindow(400, "R8 independent channels");
    compareWindow(20, "R2 frame order");
  endtask

  task automatic testIgnored();
    sendFrame(3'd5, 24'h7FFFFF, 1);
    sendFrame(3'd6, 24'h000001, 1);
    sendFrame(3'd7, 24'h400000, 1);
    compareWindow(200, "R3 unused address");
  endtask

  task automatic testContinuity();
    sendFrame(3'd1, 24'h0C0000, 1);
    compareWindow(100, "R7 phase continuity");
    sendFrame(3'd0, 24'h000000, 1);
    compareWindow(50, "R7 frozen phase");
  endtask

  task automatic testHeldShift();
    sendFrame(3'd3, 24'h155555, 3);
    compareWindow(200, "R9 held shift clock");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    testReset();
    testHalfRate();
    testWrap();
    testIndependent();
    testIgnored();
    testContinuity();
    testHeldShift();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule